// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control path of a small 16-bit processor, together with a minimal model of the state it acts on. That state is the program counter, a downward-growing stack pointer, a small stack memory, an interrupt-enable bit and a pending-request latch. Instructions arrive one at a time on a valid/ready stream. Each one carries a 2-bit operation code: 0 is an ordinary instruction, 1 enables interrupts, 2 disables interrupts and 3 is return-from-interrupt. The block can accept an instruction only while its sequencer is idle.

When an ordinary instruction completes with interrupts enabled and a request pending, the sequencer runs three single-cycle steps. First it disables interrupts. Then it pushes the already-incremented program counter. Finally it loads the program counter from the vector input. Return-from-interrupt runs two steps: it clears the pending request, then pops the program counter. It does not touch the enable bit, so a handler must enable interrupts again itself before it returns. General-purpose registers are not saved; that is left to software.

The instruction stream is subject to back-pressure. While `instr_valid` is high and `instr_ready` is low, the producer must hold `instr_op` steady. Such a held instruction has no effect until the cycle in which both signals are high. `instr_ready` stays low for three cycles after an entry begins and for two cycles after a return is accepted.

Top module: `irq_seq`

## Requirements
- R1: After reset, `pc`=PC_INIT (0), `sp`=SP_INIT (0), `int_en`=0, `int_pend`=0, `instr_ready`=1, `ctl_strobe`=0 and `bus_oe`=4'b0001.
- R2: `instr_ready` is high only while no sequence step is active. An instruction held valid while ready is low changes no state.
- R3: An accepted op 0 advances `pc` by one. If `int_en` and `int_pend` are both 1 when it is accepted, the entry sequence starts on the next cycle.
- R4: Op 1 sets `int_en` and op 2 clears it. Both advance `pc` by one, and neither starts the entry sequence, even with a request pending.
- R5: Entry step one drives `ctl_strobe` bit 0. After it, `int_en` is 0.
- R6: Entry step two drives `ctl_strobe` bit 1. It decrements `sp` by one, then writes `pc` to the stack at the new `sp`.
- R7: Entry step three drives `ctl_strobe` bit 2 and loads `pc` from `irq_vector`. The block is then ready again.
- R8: Op 3 runs a clear step (`ctl_strobe` bit 3) and then a pop step (`ctl_strobe` bit 4). The pop reloads `pc` from the stack at `sp` and then increments `sp`. `int_en` is unchanged.
- R9: `irq_req` high at a clock edge sets `int_pend`, which holds until the clear step. A request in the clear step's own cycle is discarded.
- R10: `bus_oe` is one-hot in every cycle: bit 0 none, bit 1 program counter, bit 2 stack, bit 3 vector. `ctl_strobe` has at most one bit set.
- R11: With `int_en`=0, a pending request starts no entry and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The sequencer can take an instruction |
| instr_op | input | 2 | Operation code: 0 ordinary, 1 enable, 2 disable, 3 return |
| irq_req | input | 1 | Interrupt request, sampled each edge |
| irq_vector | input | 16 | Handler address loaded in entry step three |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| int_en | output | 1 | Interrupt enable |
| int_pend | output | 1 | Pending request latch |
| ctl_strobe | output | 5 | One-hot step strobes: disable, push, vector, clear, pop |
| bus_oe | output | 4 | One-hot internal bus source select |

## Verification
A sequencer stuck in, or skipping, a step shows up within one cycle. `instr_ready` would stay low or return too early, or `ctl_strobe` would break its disable, push, vector or clear, pop order. A wrong stack pointer or a lost push shows later, at the pop. The program counter that comes back from return-from-interrupt would not equal the address pushed on entry, so nested entries followed by two returns expose any error in stack order. A wrong enable or pending latch shows at the next ordinary instruction, which would take an entry it should not take, or miss one it should.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    OP_NORM = 2'd0,
    OP_EI   = 2'd1,
    OP_DI   = 2'd2,
    OP_RTI  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIS, ST_PUSH, ST_VEC, ST_CLR, ST_POP
  } st_e;

  localparam int N_STB    = 5;
  localparam int STB_DIS  = 0;
  localparam int STB_PUSH = 1;
  localparam int STB_VEC  = 2;
  localparam int STB_CLR  = 3;
  localparam int STB_POP  = 4;

  localparam int N_SRC    = 4;
  localparam int SRC_NONE = 0;
  localparam int SRC_PC   = 1;
  localparam int SRC_STK  = 2;
  localparam int SRC_VEC  = 3;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [1:0]       instr_op,
  input  logic             irq_hit,
  output logic             instr_ready,
  output logic             accept,
  output logic [N_STB-1:0] strobe,
  output logic [N_SRC-1:0] bus_oe
);
  st_e st, st_nx;
  op_e op;

  assign op          = op_e'(instr_op);
  assign instr_ready = (st == ST_IDLE);
  assign accept      = instr_valid & instr_ready;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) begin
        if (op == OP_RTI)                  st_nx = ST_CLR;
        else if (op == OP_NORM && irq_hit) st_nx = ST_DIS;
      end
      ST_DIS:  st_nx = ST_PUSH;
      ST_PUSH: st_nx = ST_VEC;
      ST_VEC:  st_nx = ST_IDLE;
      ST_CLR:  st_nx = ST_POP;
      ST_POP:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    strobe = '0;
    bus_oe = '0;
    case (st)
      ST_DIS:  begin strobe[STB_DIS]  = 1'b1; bus_oe[SRC_NONE] = 1'b1; end
      ST_PUSH: begin strobe[STB_PUSH] = 1'b1; bus_oe[SRC_PC]   = 1'b1; end
      ST_VEC:  begin strobe[STB_VEC]  = 1'b1; bus_oe[SRC_VEC]  = 1'b1; end
      ST_CLR:  begin strobe[STB_CLR]  = 1'b1; bus_oe[SRC_NONE] = 1'b1; end
      ST_POP:  begin strobe[STB_POP]  = 1'b1; bus_oe[SRC_STK]  = 1'b1; end
      default: bus_oe[SRC_NONE] = 1'b1;
    endcase
  end

  // R10
  bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(bus_oe));
  // R10
  strobe_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> !instr_ready);
  // R3
  entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_NORM && irq_hit) |=> strobe[STB_DIS]);
  // R4
  no_entry_on_ei_di_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_EI || op == OP_DI)) |=> !strobe[STB_DIS]);
  // R6
  dis_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_DIS] |=> strobe[STB_PUSH]);
  // R7
  push_then_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_PUSH] |=> strobe[STB_VEC]);
  // R8
  clr_then_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_CLR] |=> strobe[STB_POP]);
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
  import irq_seq_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            STK_DEPTH = 16,
  parameter logic [DW-1:0] PC_INIT   = '0,
  parameter logic [DW-1:0] SP_INIT   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       instr_op,
  input  logic [N_STB-1:0] strobe,
  input  logic [N_SRC-1:0] bus_oe,
  input  logic             irq_req,
  input  logic [DW-1:0]    irq_vector,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    sp,
  output logic             int_en,
  output logic             int_pend,
  output logic             irq_hit
);
  localparam int            AW  = $clog2(STK_DEPTH);
  localparam logic [DW-1:0] ONE = 1;

  op_e           op;
  logic [DW-1:0] bus_data;
  logic [DW-1:0] sp_dec;
  logic [DW-1:0] stk [STK_DEPTH];

  assign op      = op_e'(instr_op);
  assign sp_dec  = sp - ONE;
  assign irq_hit = int_en & int_pend;

  always_comb begin
    bus_data = '0;
    if (bus_oe[SRC_PC])  bus_data = pc;
    if (bus_oe[SRC_STK]) bus_data = stk[sp[AW-1:0]];
    if (bus_oe[SRC_VEC]) bus_data = irq_vector;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= PC_INIT;
      sp       <= SP_INIT;
      int_en   <= 1'b0;
      int_pend <= 1'b0;
    end else begin
      if (accept && op != OP_RTI)              pc <= pc + ONE;
      if (strobe[STB_VEC] || strobe[STB_POP])  pc <= bus_data;
      if (strobe[STB_PUSH])                    sp <= sp_dec;
      if (strobe[STB_POP])                     sp <= sp + ONE;
      if (accept && op == OP_EI)               int_en <= 1'b1;
      if (accept && op == OP_DI)               int_en <= 1'b0;
      if (strobe[STB_DIS])                     int_en <= 1'b0;
      int_pend <= (int_pend | irq_req) & ~strobe[STB_CLR];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe[STB_PUSH]) stk[sp_dec[AW-1:0]] <= bus_data;
  end

  // R5
  ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_DIS] |=> !int_en);
  // R6
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_PUSH] |=> sp == $past(sp) - ONE);
  // R7
  vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_VEC] |=> pc == $past(irq_vector));
  // R8
  pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_POP] |=> sp == $past(sp) + ONE);
  // R8
  rti_keeps_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[STB_CLR] || strobe[STB_POP]) |=> $stable(int_en));
  // R9
  clr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_CLR] |=> !int_pend);
  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend && !strobe[STB_CLR]) |=> int_pend);
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            STK_DEPTH = 16,
  parameter logic [DW-1:0] PC_INIT   = '0,
  parameter logic [DW-1:0] SP_INIT   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  output logic             instr_ready,
  input  logic [1:0]       instr_op,
  input  logic             irq_req,
  input  logic [DW-1:0]    irq_vector,
  output logic [DW-1:0]    pc,
  output logic [DW-1:0]    sp,
  output logic             int_en,
  output logic             int_pend,
  output logic [N_STB-1:0] ctl_strobe,
  output logic [N_SRC-1:0] bus_oe
);
  logic accept;
  logic irq_hit;

  irq_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .irq_hit     (irq_hit),
    .instr_ready (instr_ready),
    .accept      (accept),
    .strobe      (ctl_strobe),
    .bus_oe      (bus_oe)
  );

  irq_seq_regs #(
    .DW        (DW),
    .STK_DEPTH (STK_DEPTH),
    .PC_INIT   (PC_INIT),
    .SP_INIT   (SP_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .instr_op   (instr_op),
    .strobe     (ctl_strobe),
    .bus_oe     (bus_oe),
    .irq_req    (irq_req),
    .irq_vector (irq_vector),
    .pc         (pc),
    .sp         (sp),
    .int_en     (int_en),
    .int_pend   (int_pend),
    .irq_hit    (irq_hit)
  );
endmodule

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic        instr_ready;
  logic [1:0]  instr_op;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic [15:0] pc;
  logic [15:0] sp;
  logic        int_en;
  logic        int_pend;
  logic [4:0]  ctl_strobe;
  logic [3:0]  bus_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_seq i_irq_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .irq_req(irq_req), .irq_vector(irq_vector), .pc(pc), .sp(sp),
    .int_en(int_en), .int_pend(int_pend), .ctl_strobe(ctl_strobe), .bus_oe(bus_oe)
  );

  // {op[2], irq_before[1], pc[16], sp[16], int_en[1], int_pend[1]}
  localparam logic [36:0] TBL [16] = '{
    {2'd0, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'h0002, 16'h0000, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h0003, 16'h0000, 1'b1, 1'b1},
    {2'd0, 1'b0, 16'h4000, 16'hFFFF, 1'b0, 1'b1},
    {2'd0, 1'b0, 16'h4001, 16'hFFFF, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h4002, 16'hFFFF, 1'b1, 1'b1},
    {2'd3, 1'b0, 16'h0004, 16'h0000, 1'b1, 1'b0},
    {2'd0, 1'b0, 16'h0005, 16'h0000, 1'b1, 1'b0},
    {2'd2, 1'b1, 16'h0006, 16'h0000, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h0007, 16'h0000, 1'b1, 1'b1},
    {2'd0, 1'b0, 16'h4000, 16'hFFFF, 1'b0, 1'b1},
    {2'd1, 1'b0, 16'h4001, 16'hFFFF, 1'b1, 1'b1},
    {2'd0, 1'b0, 16'h4000, 16'hFFFE, 1'b0, 1'b1},
    {2'd3, 1'b0, 16'h4002, 16'hFFFF, 1'b0, 1'b0},
    {2'd3, 1'b0, 16'h0008, 16'h0000, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0009, 16'h0000, 1'b1, 1'b0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; instr_op = 2'd0; irq_req = 1'b0;
    irq_vector = 16'h4000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "pc", 32'(pc), 32'h0);
    check("R1", "sp", 32'(sp), 32'h0);
    check("R1", "int_en", 32'(int_en), 32'h0);
    check("R1", "int_pend", 32'(int_pend), 32'h0);
    check("R1", "ready", 32'(instr_ready), 32'h1);
    check("R1", "strobe", 32'(ctl_strobe), 32'h0);
    check("R1", "bus_oe", 32'(bus_oe), 32'h1);

    // table walk: R3 pc, R6 sp, R4 enable, R9 pending, R8 and R11 via rows
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      irq_req = TBL[i][34]; instr_valid = 1'b0;
      @(negedge clk);
      irq_req = 1'b0; instr_valid = 1'b1; instr_op = TBL[i][36:35];
      @(negedge clk);
      instr_valid = 1'b0;
      while (!instr_ready) @(negedge clk);
      check("R3", $sformatf("row %0d pc", i), 32'(pc), 32'(TBL[i][33:18]));
      check("R6", $sformatf("row %0d sp", i), 32'(sp), 32'(TBL[i][17:2]));
      check("R4", $sformatf("row %0d int_en", i), 32'(int_en), 32'(TBL[i][1]));
      check("R11", $sformatf("row %0d int_pend", i), 32'(int_pend), 32'(TBL[i][0]));
    end

    // directed entry trace, instruction held valid through the busy steps
    irq_vector = 16'h1234;
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0; instr_valid = 1'b1; instr_op = 2'd0;
    @(negedge clk);
    check("R5", "step1 strobe", 32'(ctl_strobe), 32'h01);
    check("R10", "step1 bus", 32'(bus_oe), 32'h1);
    check("R2", "step1 ready", 32'(instr_ready), 32'h0);
    check("R3", "pc advanced", 32'(pc), 32'h000A);
    @(negedge clk);
    check("R6", "step2 strobe", 32'(ctl_strobe), 32'h02);
    check("R10", "step2 bus", 32'(bus_oe), 32'h2);
    check("R5", "int_en off", 32'(int_en), 32'h0);
    @(negedge clk);
    check("R7", "step3 strobe", 32'(ctl_strobe), 32'h04);
    check("R10", "step3 bus", 32'(bus_oe), 32'h8);
    check("R6", "sp dec", 32'(sp), 32'hFFFF);
    @(negedge clk);
    check("R7", "pc vector", 32'(pc), 32'h1234);
    check("R7", "ready back", 32'(instr_ready), 32'h1);
    check("R2", "held op not consumed", 32'(ctl_strobe), 32'h0);
    instr_valid = 1'b0;

    // directed return trace, request arriving in the clear cycle
    @(negedge clk); instr_valid = 1'b1; instr_op = 2'd3;
    @(negedge clk); instr_valid = 1'b0;
    check("R8", "clear strobe", 32'(ctl_strobe), 32'h08);
    check("R10", "clear bus", 32'(bus_oe), 32'h1);
    irq_req = 1'b1;
    @(negedge clk); irq_req = 1'b0;
    check("R8", "pop strobe", 32'(ctl_strobe), 32'h10);
    check("R10", "pop bus", 32'(bus_oe), 32'h4);
    check("R9", "clear wins", 32'(int_pend), 32'h0);
    @(negedge clk);
    check("R8", "pc restored", 32'(pc), 32'h000A);
    check("R8", "sp restored", 32'(sp), 32'h0000);
    check("R8", "int_en unchanged", 32'(int_en), 32'h0);
    check("R2", "ready after return", 32'(instr_ready), 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule